// File: doc/BRIEF.md
# Latched Sixteen-Bit Arithmetic and Logic Unit

This block is a 16-bit arithmetic and logic unit placed between two holding registers. A first strobe samples the shared data input into an operand register, which then supplies operand A. In a later cycle the data input carries operand B, a 4-bit function code picks the operation, and a second strobe stores the function's value in a result register that drives the output. The result stays there until the next result strobe, so a controller can take several cycles to move it to its destination.

The function code chooses one of nine operations: three bitwise two-operand logic functions, bitwise inversion of A, two's-complement addition and subtraction, increment, decrement and clear. Code 0000 and every code that is not assigned pass A through unchanged. Each register changes only on its own strobe or on the synchronous reset.

Top module: `enc_alu_latched`

## Requirements
- R1: A synchronous active-high reset clears the operand register and the result register to zero. After reset `result` is 0, and a pass operation (code 0000) with no operand load in between also gives 0.
- R2: When `opnd_ld` is high at a rising edge, the operand register takes `data_in`. When it is low, the operand register keeps its value, whatever `data_in` does.
- R3: When `res_ld` is high at a rising edge, `result` takes the function value computed from the operand register, `data_in` (as B) and `fn_sel`. When it is low, `result` keeps its value.
- R4: Code 0001 gives A AND B, code 0010 gives A OR B, code 0100 gives A XOR B, all bitwise.
- R5: Code 0011 gives the bitwise inversion of A. B has no effect.
- R6: Code 0101 gives A+B and code 0110 gives A−B, both modulo 2^16.
- R7: Code 0111 gives A+1 and code 1000 gives A−1, both modulo 2^16 (0xFFFF+1 = 0, 0−1 = 0xFFFF).
- R8: Code 1001 gives 0x0000 for every A and B.
- R9: Code 0000 and codes 1010 to 1111 give A unchanged.
- R10: When `opnd_ld` and `res_ld` are both high at the same edge, the result uses the operand value held before that edge, and the operand register takes `data_in` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opnd_ld | input | 1 | Strobe that stores `data_in` as operand A |
| res_ld | input | 1 | Strobe that stores the function value in the result register |
| fn_sel | input | 4 | Function code |
| data_in | input | 16 | Shared data input: operand A when `opnd_ld` is high, operand B when the result is computed |
| result | output | 16 | Result register output |

## Verification
All sixteen function codes are applied to several operand pairs. Complementary bit patterns show whether AND, OR and XOR were swapped. Operand pairs with carries and borrows at the 16-bit edges show whether addition and subtraction wrap correctly and are not swapped. A = 0xFFFF and A = 0 expose wrong wrap-around in increment and decrement. Varying B under the single-operand codes shows that B leaks into none of them. Sequences that change `data_in` while one strobe is low show whether each register really holds its value, and the combined-strobe case shows which operand value the result register sees.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_PASS = 4'b0000,
        FN_AND  = 4'b0001,
        FN_OR   = 4'b0010,
        FN_INV  = 4'b0011,
        FN_XOR  = 4'b0100,
        FN_ADD  = 4'b0101,
        FN_SUB  = 4'b0110,
        FN_INC  = 4'b0111,
        FN_DEC  = 4'b1000,
        FN_CLR  = 4'b1001
    } alu_fn_e;

    // Strobes and function code applied in one cycle
    typedef struct packed {
        logic    opnd_ld;
        logic    res_ld;
        alu_fn_e fn;
    } alu_ctl_t;

    function automatic alu_fn_e to_fn(input logic [FN_W-1:0] code);
        return alu_fn_e'(code);
    endfunction

endpackage

// File: rtl/alu_hold_reg.sv
module alu_hold_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end
    end

endmodule

// File: rtl/alu_func.sv
module alu_func
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        case (fn)
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_INV:  y = ~a;
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_INC:  y = a + ONE;
            FN_DEC:  y = a - ONE;
            FN_CLR:  y = '0;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/enc_alu_latched.sv
module enc_alu_latched
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            opnd_ld,
    input  logic            res_ld,
    input  logic [FN_W-1:0] fn_sel,
    input  logic [W-1:0]    data_in,
    output logic [W-1:0]    result
);

    alu_ctl_t     ctl;
    logic [W-1:0] opnd_q;
    logic [W-1:0] fn_y;

    always_comb begin
        ctl.opnd_ld = opnd_ld;
        ctl.res_ld  = res_ld;
        ctl.fn      = to_fn(fn_sel);
    end

    alu_hold_reg #(.W(W)) u_opnd (
        .clk (clk),
        .rst (rst),
        .ld  (ctl.opnd_ld),
        .d   (data_in),
        .q   (opnd_q)
    );

    alu_func #(.W(W)) u_func (
        .fn (ctl.fn),
        .a  (opnd_q),
        .b  (data_in),
        .y  (fn_y)
    );

    alu_hold_reg #(.W(W)) u_res (
        .clk (clk),
        .rst (rst),
        .ld  (ctl.res_ld),
        .d   (fn_y),
        .q   (result)
    );

endmodule

// File: rtl/enc_alu_latched_chk.sv
module enc_alu_latched_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         opnd_ld,
    input logic         res_ld,
    input logic [3:0]   fn_sel,
    input logic [W-1:0] data_in,
    input logic [W-1:0] opnd_q,
    input logic [W-1:0] result
);

    logic rst_d;
    always_ff @(posedge clk) begin
        rst_d <= rst;
        // R1
        if (rst_d === 1'b1) begin
            reset_clear_chk: assert (result == '0 && opnd_q == '0);
        end
    end

    // R2
    opnd_load_chk: assert property (@(posedge clk) disable iff (rst)
        opnd_ld |=> opnd_q == $past(data_in));

    // R2
    opnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !opnd_ld |=> opnd_q == $past(opnd_q));

    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !res_ld |=> $stable(result));

    // R7
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (res_ld && fn_sel == 4'b0111) |=> result == $past(opnd_q) + W'(1));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (res_ld && fn_sel == 4'b1001) |=> result == '0);

    // R9
    pass_chk: assert property (@(posedge clk) disable iff (rst)
        (res_ld && (fn_sel == 4'b0000 || fn_sel >= 4'b1010)) |=> result == $past(opnd_q));

endmodule

bind enc_alu_latched enc_alu_latched_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .opnd_ld (opnd_ld),
    .res_ld  (res_ld),
    .fn_sel  (fn_sel),
    .data_in (data_in),
    .opnd_q  (opnd_q),
    .result  (result)
);

// File: tb/enc_alu_latched_test.sv
`timescale 1ns/1ps
module enc_alu_latched_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        opnd_ld;
    logic        res_ld;
    logic [3:0]  fn_sel;
    logic [15:0] data_in;
    logic [15:0] result;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    enc_alu_latched uut (
        .clk     (clk),
        .rst     (rst),
        .opnd_ld (opnd_ld),
        .res_ld  (res_ld),
        .fn_sel  (fn_sel),
        .data_in (data_in),
        .result  (result)
    );

    function automatic logic [15:0] model(input logic [3:0] c, input logic [15:0] a,
                                          input logic [15:0] b);
        case (c)
            4'b0001: return a & b;
            4'b0010: return a | b;
            4'b0100: return a ^ b;
            4'b0011: return ~a;
            4'b0101: return a + b;
            4'b0110: return a - b;
            4'b0111: return a + 16'd1;
            4'b1000: return a - 16'd1;
            4'b1001: return 16'h0000;
            default: return a;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'b0001, 4'b0010, 4'b0100: return "R4";
            4'b0011: return "R5";
            4'b0101, 4'b0110: return "R6";
            4'b0111, 4'b1000: return "R7";
            4'b1001: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        n_run++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: result=%h expected=%h", req, result, exp);
        end
    endtask

    // Inputs change at the falling edge; result is sampled one falling edge
    // after the capturing rising edge.
    task automatic load_a(input logic [15:0] a);
        @(negedge clk);
        opnd_ld = 1'b1; res_ld = 1'b0; data_in = a;
        @(negedge clk);
        opnd_ld = 1'b0;
    endtask

    task automatic compute(input logic [3:0] c, input logic [15:0] b);
        res_ld = 1'b1; fn_sel = c; data_in = b;
        @(negedge clk);
        res_ld = 1'b0;
    endtask

    task automatic op_case(input logic [3:0] c, input logic [15:0] a, input logic [15:0] b);
        load_a(a);
        compute(c, b);
        check(req_of(c), model(c, a, b));
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; opnd_ld = 1'b1; res_ld = 1'b1; fn_sel = 4'b0000; data_in = 16'h1234;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; opnd_ld = 1'b0; res_ld = 1'b0;
        check("R1", 16'h0000);
        compute(4'b0000, 16'hBEEF);
        check("R1", 16'h0000);
    endtask

    task automatic t_logic;
        op_case(4'b0001, 16'hF0F0, 16'hFF00);
        op_case(4'b0010, 16'hF0F0, 16'h0F0F);
        op_case(4'b0100, 16'hAAAA, 16'hFF00);
        op_case(4'b0001, 16'h1234, 16'h5678);
        op_case(4'b0010, 16'h1234, 16'h5678);
        op_case(4'b0100, 16'h1234, 16'h5678);
    endtask

    task automatic t_inv;
        op_case(4'b0011, 16'h00FF, 16'h0000);
        op_case(4'b0011, 16'h00FF, 16'hFFFF);
    endtask

    task automatic t_arith;
        op_case(4'b0101, 16'h1234, 16'h0F0F);
        op_case(4'b0101, 16'hFFFF, 16'h0002);
        op_case(4'b0110, 16'h5000, 16'h1234);
        op_case(4'b0110, 16'h0001, 16'h0003);
    endtask

    task automatic t_incdec;
        op_case(4'b0111, 16'hFFFF, 16'h5555);
        op_case(4'b0111, 16'h7FFF, 16'h0000);
        op_case(4'b1000, 16'h0000, 16'hAAAA);
        op_case(4'b1000, 16'h8000, 16'h0000);
    endtask

    task automatic t_clear;
        op_case(4'b1001, 16'hFFFF, 16'hFFFF);
        op_case(4'b1001, 16'h1357, 16'h2468);
    endtask

    task automatic t_pass_all;
        for (int c = 0; c < 16; c++) begin
            op_case(4'(c), 16'hC3A5 ^ 16'(c * 16'h0111), 16'h5A3C);
        end
    endtask

    task automatic t_hold;
        logic [15:0] keep;
        load_a(16'h4321);
        compute(4'b0101, 16'h0001);
        keep = 16'h4322;
        // R3: no res_ld, inputs wander
        data_in = 16'hFFFF; fn_sel = 4'b1001;
        @(negedge clk);
        data_in = 16'h0000; fn_sel = 4'b0011;
        @(negedge clk);
        check("R3", keep);
        // R2: operand register keeps 0x4321 while data_in changes
        data_in = 16'h9999;
        @(negedge clk);
        compute(4'b0000, 16'h7777);
        check("R2", 16'h4321);
    endtask

    task automatic t_same_edge;
        load_a(16'h0005);
        opnd_ld = 1'b1; res_ld = 1'b1; fn_sel = 4'b0000; data_in = 16'h0009;
        @(negedge clk);
        opnd_ld = 1'b0; res_ld = 1'b0;
        check("R10", 16'h0005);
        compute(4'b0000, 16'h0000);
        check("R10", 16'h0009);
    endtask

    initial begin
        rst = 1'b1; opnd_ld = 1'b0; res_ld = 1'b0; fn_sel = 4'b0000; data_in = 16'h0000;
        t_reset();
        t_logic();
        t_inv();
        t_arith();
        t_incdec();
        t_clear();
        t_pass_all();
        t_hold();
        t_same_edge();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule